// File: doc/BRIEF.md
# Programmable Conversion Cycle Scheduler

This block paces the repeating measurement cycles of a low-power sensing front end. It counts millisecond ticks and raises a one-cycle start pulse at the beginning of each conversion. It holds a busy flag while the conversion runs and raises a one-cycle done pulse when the conversion ends. It then idles until the next period begins. The length of the conversion and the start-to-start period come from two 2-bit configuration fields. The resolution field picks how many result bits are meaningful, and the delay field picks how far apart conversions start.

Both durations shrink by half for each step down in resolution. The block also supplies a 13-bit mask for the converter result. The mask keeps the sign and the magnitude bits that are valid at the active resolution. Configuration is captured only when a conversion starts, so a cycle that is already running keeps its settings.

Top module: `conv_sched`

## Requirements
- R1: While reset is asserted, and after it is released until the first tick, start, done and busy are low. The active resolution reads 3 (12-bit) and the result mask reads 13'h1FFF. The captured delay code reads 0.
- R2: The first ms_tick after reset is released produces a start pulse and raises busy. Both are visible in the clock cycle after the tick.
- R3: The resolution code r (0..3 on cfg_res) selects a conversion length of 240 >> (3 - r) ticks: 30, 60, 120 or 240. Done pulses on the tick that is that many ticks after the start tick. Busy falls with done unless a new start occurs on the same tick.
- R4: The delay code d selects a start-to-start period of 500, 1000 or 8000 ticks for d = 1, 2, 3, each shifted right by (3 - r). The period is never shorter than the conversion length. The next start pulse comes on the tick that is that many ticks after the previous start tick.
- R5: With delay code 0, the period equals the conversion length. Done and the next start pulse appear in the same cycle, and busy stays high with no idle cycles.
- R6: cfg_res and cfg_dly are sampled only on a tick that starts a conversion. Changes at any other time do not alter the running cycle's done or next-start timing. They also do not alter the act_res output.
- R7: res_mask bit 12 is the sign and is always set. Bits 11..0 are magnitude. The mask sets the top 9 + r magnitude bits and clears the lowest 3 - r bits, where r is the active resolution.
- R8: Start and done are single-cycle pulses and appear only in the cycle after a tick. In a cycle that follows no tick, busy keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| ms_tick | input | 1 | One-cycle timebase strobe, one per millisecond |
| cfg_res | input | 2 | Requested resolution code (0 = 9 bits .. 3 = 12 bits) |
| cfg_dly | input | 2 | Requested delay code (0 = back-to-back .. 3 = longest period) |
| conv_start | output | 1 | One-cycle pulse at the start of each conversion |
| conv_busy | output | 1 | High while a conversion is running |
| conv_done | output | 1 | One-cycle pulse at the end of each conversion |
| act_res | output | 2 | Resolution captured at the latest start |
| res_mask | output | 13 | Valid-bit mask for the converter result |

## Verification
The bound checker watches on every cycle that pulses last one cycle and only follow ticks. It also checks that busy rises with start and falls with a lone done. It checks that the active resolution moves only at a start and that the mask popcount matches the active resolution. Exact tick distances cannot be seen from a one-cycle window. These are the 30..240-tick conversion lengths, the non-uniform period table with its 8000-tick top entry, and the clamp. The bench scenarios measure them by counting ticks between events. This covers random tick gaps and configuration changes made in the middle of a running cycle.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;
  typedef enum logic [1:0] {
    PH_ARMED = 2'd0,
    PH_CONV  = 2'd1,
    PH_IDLE  = 2'd2
  } phase_e;
endpackage

// File: rtl/conv_sched_duration.sv
module conv_sched_duration #(
  parameter int CONV_BASE = 240,
  parameter int PER_BASE1 = 500,
  parameter int PER_BASE2 = 1000,
  parameter int PER_BASE3 = 8000,
  parameter int CNT_W     = 13,
  parameter int CODE_W    = 2
) (
  input  logic [CODE_W-1:0] res_i,
  input  logic [CODE_W-1:0] dly_i,
  output logic [CNT_W-1:0]  conv_len_o,
  output logic [CNT_W-1:0]  per_len_o
);
  localparam logic [CNT_W-1:0] CONV_B = CNT_W'(CONV_BASE);
  localparam logic [CNT_W-1:0] PER_B1 = CNT_W'(PER_BASE1);
  localparam logic [CNT_W-1:0] PER_B2 = CNT_W'(PER_BASE2);
  localparam logic [CNT_W-1:0] PER_B3 = CNT_W'(PER_BASE3);

  logic [CODE_W-1:0] shift;
  logic [CNT_W-1:0]  per_raw;

  // each step below full resolution halves the duration
  assign shift      = ~res_i;
  assign conv_len_o = CONV_B >> shift;

  always_comb begin
    case (dly_i)
      2'd1:    per_raw = PER_B1 >> shift;
      2'd2:    per_raw = PER_B2 >> shift;
      2'd3:    per_raw = PER_B3 >> shift;
      default: per_raw = conv_len_o;
    endcase
  end

  assign per_len_o = (per_raw < conv_len_o) ? conv_len_o : per_raw;
endmodule

// File: rtl/conv_sched_mask.sv
module conv_sched_mask #(
  parameter int MAG_W   = 12,
  parameter int MIN_MAG = 9,
  parameter int CODE_W  = 2
) (
  input  logic [CODE_W-1:0] res_i,
  output logic [MAG_W:0]    mask_o
);
  localparam int SPAN = MAG_W - MIN_MAG;

  logic [CODE_W-1:0] drop;
  assign drop = CODE_W'(SPAN) - res_i;

  for (genvar i = 0; i <= MAG_W; i++) begin : g_bit
    if (i >= SPAN) begin : g_fixed
      assign mask_o[i] = 1'b1;
    end else begin : g_var
      assign mask_o[i] = (CODE_W'(i) >= drop);
    end
  end
endmodule

// File: rtl/conv_sched_seq.sv
module conv_sched_seq
  import conv_sched_pkg::*;
#(
  parameter int CNT_W  = 13,
  parameter int CODE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] cfg_res_i,
  input  logic [CODE_W-1:0] cfg_dly_i,
  input  logic [CNT_W-1:0]  conv_len_i,
  input  logic [CNT_W-1:0]  per_len_i,
  output logic [CODE_W-1:0] res_o,
  output logic [CODE_W-1:0] dly_o,
  output logic              start_o,
  output logic              done_o,
  output logic              busy_o
);
  phase_e            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_inc;
  logic [CODE_W-1:0] res_q, res_d, dly_q, dly_d;
  logic              start_q, start_d, done_q, done_d;
  logic              hit_conv, hit_per;

  assign cnt_inc  = cnt_q + 1'b1;
  assign hit_conv = (phase_q == PH_CONV) && (cnt_inc == conv_len_i);
  assign hit_per  = (phase_q != PH_ARMED) && (cnt_inc == per_len_i);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    res_d   = res_q;
    dly_d   = dly_q;
    start_d = 1'b0;
    done_d  = 1'b0;
    if (tick_i) begin
      done_d = hit_conv;
      if (phase_q == PH_ARMED || hit_per) begin
        phase_d = PH_CONV;
        cnt_d   = '0;
        res_d   = cfg_res_i;
        dly_d   = cfg_dly_i;
        start_d = 1'b1;
      end else begin
        cnt_d = cnt_inc;
        if (hit_conv) phase_d = PH_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_ARMED;
      cnt_q   <= '0;
      res_q   <= '1;
      dly_q   <= '0;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      start_q <= start_d;
      done_q  <= done_d;
      if (tick_i) begin
        phase_q <= phase_d;
        cnt_q   <= cnt_d;
        res_q   <= res_d;
        dly_q   <= dly_d;
      end
    end
  end

  assign res_o   = res_q;
  assign dly_o   = dly_q;
  assign start_o = start_q;
  assign done_o  = done_q;
  assign busy_o  = (phase_q == PH_CONV);
endmodule

// File: rtl/conv_sched.sv
module conv_sched #(
  parameter int CONV_BASE = 240,
  parameter int PER_BASE1 = 500,
  parameter int PER_BASE2 = 1000,
  parameter int PER_BASE3 = 8000,
  parameter int MAG_W     = 12,
  parameter int MIN_MAG   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ms_tick,
  input  logic [1:0]       cfg_res,
  input  logic [1:0]       cfg_dly,
  output logic             conv_start,
  output logic             conv_busy,
  output logic             conv_done,
  output logic [1:0]       act_res,
  output logic [MAG_W:0]   res_mask
);
  localparam int CODE_W = 2;
  localparam int CNT_W  = $clog2(PER_BASE3 + 1);

  logic [CNT_W-1:0]  conv_len, per_len;
  logic [CODE_W-1:0] res_q, dly_q;

  conv_sched_duration #(
    .CONV_BASE(CONV_BASE), .PER_BASE1(PER_BASE1), .PER_BASE2(PER_BASE2),
    .PER_BASE3(PER_BASE3), .CNT_W(CNT_W), .CODE_W(CODE_W)
  ) u_dur (
    .res_i(res_q), .dly_i(dly_q), .conv_len_o(conv_len), .per_len_o(per_len)
  );

  conv_sched_seq #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick_i(ms_tick),
    .cfg_res_i(cfg_res), .cfg_dly_i(cfg_dly),
    .conv_len_i(conv_len), .per_len_i(per_len),
    .res_o(res_q), .dly_o(dly_q),
    .start_o(conv_start), .done_o(conv_done), .busy_o(conv_busy)
  );

  conv_sched_mask #(.MAG_W(MAG_W), .MIN_MAG(MIN_MAG), .CODE_W(CODE_W)) u_mask (
    .res_i(res_q), .mask_o(res_mask)
  );

  assign act_res = res_q;
endmodule

// File: rtl/conv_sched_chk.sv
module conv_sched_chk #(
  parameter int MAG_W = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ms_tick,
  input logic           conv_start,
  input logic           conv_busy,
  input logic           conv_done,
  input logic [1:0]     act_res,
  input logic [MAG_W:0] res_mask
);
  p_busy_at_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> conv_busy);

  p_busy_falls_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && !conv_start) |-> !conv_busy);

  p_backtoback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && conv_start) |-> conv_busy);

  p_res_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_start |-> $stable(act_res));

  p_mask_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_mask[MAG_W] && ($countones(res_mask) == 32'(act_res) + 10));

  p_start_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !conv_done);

  p_quiet_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ms_tick |=> (!conv_start && !conv_done && $stable(conv_busy)));
endmodule

bind conv_sched conv_sched_chk #(.MAG_W(MAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
  .conv_start(conv_start), .conv_busy(conv_busy), .conv_done(conv_done),
  .act_res(act_res), .res_mask(res_mask)
);

// File: tb/conv_sched_bench.sv
`timescale 1ns/1ps
module conv_sched_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ms_tick = 1'b0;
  logic [1:0]  cfg_res = 2'd3;
  logic [1:0]  cfg_dly = 2'd0;
  logic        conv_start, conv_busy, conv_done;
  logic [1:0]  act_res;
  logic [12:0] res_mask;

  int checks = 0;
  int errors = 0;
  int tick_n = 0;
  int st_tick = 0;
  int n_starts = 0;
  bit armed = 1'b1;
  bit in_conv = 1'b0;
  bit mon_on = 1'b0;
  bit finished = 1'b0;
  logic [1:0] cur_res = 2'd3;
  logic [1:0] cur_dly = 2'd0;

  always #10 clk = ~clk;

  conv_sched u_conv_sched (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
    .cfg_res(cfg_res), .cfg_dly(cfg_dly),
    .conv_start(conv_start), .conv_busy(conv_busy), .conv_done(conv_done),
    .act_res(act_res), .res_mask(res_mask)
  );

  function automatic int conv_len(input logic [1:0] r);
    return 240 >> (3 - int'(r));
  endfunction

  function automatic int per_len(input logic [1:0] r, input logic [1:0] d);
    int p;
    case (d)
      2'd1: p = 500 >> (3 - int'(r));
      2'd2: p = 1000 >> (3 - int'(r));
      2'd3: p = 8000 >> (3 - int'(r));
      default: p = conv_len(r);
    endcase
    return (p < conv_len(r)) ? conv_len(r) : p;
  endfunction

  function automatic logic [12:0] mask_of(input logic [1:0] r);
    return 13'h1FFF & ~13'((1 << (3 - int'(r))) - 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: samples 5 ns after each rising edge, while tick and config are still the sampled values
  always @(posedge clk) begin
    #5;
    if (rst_n && mon_on) begin
      if (ms_tick) begin
        bit exp_start, exp_done;
        string rq;
        tick_n++;
        exp_done  = !armed && in_conv && (tick_n - st_tick == conv_len(cur_res));
        exp_start = armed || (tick_n - st_tick == per_len(cur_res, cur_dly));
        rq = armed ? "R2 first start" : ((cur_dly == 2'd0) ? "R5 back-to-back start" : "R4 period");
        check(conv_start == exp_start, rq, conv_start, exp_start);
        check(conv_done == exp_done, (cur_dly == 2'd0) ? "R5 done" : "R3 conversion length",
              conv_done, exp_done);
        if (exp_done) in_conv = 1'b0;
        if (exp_start) begin
          armed = 1'b0;
          st_tick = tick_n;
          cur_res = cfg_res;
          cur_dly = cfg_dly;
          in_conv = 1'b1;
          n_starts++;
          check(act_res == cur_res, "R6 resolution captured at start", act_res, cur_res);
          check(res_mask == mask_of(cur_res), "R7 mask", res_mask, mask_of(cur_res));
        end
        check(conv_busy == in_conv, "R3 busy", conv_busy, in_conv);
      end else begin
        check(!conv_start && !conv_done, "R8 no pulse without tick",
              {conv_start, conv_done}, 0);
        check(conv_busy == in_conv, "R8 busy held", conv_busy, in_conv);
        check(act_res == cur_res, "R6 resolution held", act_res, cur_res);
      end
    end
  end

  task automatic pick_cfg(output logic [1:0] r, output logic [1:0] d);
    r = 2'($urandom % 4);
    d = 2'($urandom % 4);
    if (d == 2'd3 && r > 2'd1) d = 2'($urandom % 3);
  endtask

  task automatic segment(input logic [1:0] r, input logic [1:0] d, input int starts,
                         input int tick_pct, input bit change);
    int target;
    bit changed;
    logic [1:0] nr, nd;
    changed = 1'b0;
    @(negedge clk);
    cfg_res = r;
    cfg_dly = d;
    target = n_starts + starts;
    while (n_starts < target) begin
      @(negedge clk);
      ms_tick = (int'($urandom % 100) < tick_pct);
      if (change && !changed && in_conv && ($urandom % 40 == 0)) begin
        pick_cfg(nr, nd);
        cfg_res = nr;
        cfg_dly = nd;
        changed = 1'b1;
      end
    end
    @(negedge clk);
    ms_tick = 1'b0;
  endtask

  initial begin
    logic [1:0] r, d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    check(!conv_start && !conv_busy && !conv_done, "R1 outputs in reset",
          {conv_start, conv_busy, conv_done}, 0);
    check(act_res == 2'd3, "R1 active resolution", act_res, 3);
    check(res_mask == 13'h1FFF, "R1 mask", res_mask, 13'h1FFF);
    cfg_res = 2'd0;
    cfg_dly = 2'd2;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!conv_busy && !conv_start && act_res == 2'd3, "R1 idle before first tick",
          {conv_busy, conv_start, act_res}, 3);
    mon_on = 1'b1;
    // R2 first tick starts, config captured then (res 0, delay 2)
    segment(2'd0, 2'd2, 3, 100, 1'b0);
    // R5 back-to-back at full resolution
    segment(2'd3, 2'd0, 3, 100, 1'b0);
    // R3/R4 all resolutions, sparse ticks
    segment(2'd2, 2'd1, 2, 60, 1'b0);
    segment(2'd1, 2'd0, 2, 80, 1'b0);
    segment(2'd0, 2'd3, 2, 90, 1'b0);
    // R6 random configs changed mid-cycle
    for (int k = 0; k < 12; k++) begin
      pick_cfg(r, d);
      segment(r, d, 2, 75, 1'b1);
    end
    // R4 longest period at full resolution
    segment(2'd3, 2'd3, 2, 100, 1'b0);
    repeat (20) @(negedge clk);
    summary();
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_starts, 0);
    summary();
  end
endmodule